// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Per-Entry Page Size

This block translates a 64-bit virtual address into a 41-bit physical page frame. It keeps a parameterised number of entries (64 by default) and searches all of them in parallel. Each entry holds a virtual page number (address bits 63:13), a 13-bit context, a physical page number (address bits 40:13) and a set of attribute flags. The flags are valid, global, privileged, writable, side-effect, no-fault-only and a 2-bit page size. A used flag is kept per entry beside them. Entries are written one at a time through a write port. Replacement and demapping are handled elsewhere.

A lookup carries the address, the access kind, the user/privileged state, a context selector and the trap-level state. The response says whether the access hit cleanly, missed, faulted or hit a write-protection violation. A clean hit also returns the physical page and the granted permissions. The block keeps three registers that the rest of the core reads: a fault status word, a fault address and a tag-access word. Misses, faults and protection violations update them according to the rules below.

Control is a three-state machine:
- `S_IDLE` accepts a request (transition *accept*).
- `S_MATCH` runs the parallel compare and latches the winning entry (transition *resolve*, unconditional).
- `S_RESP` presents the response for one cycle and commits the register and used-flag updates (transition *retire*, back to `S_IDLE`).

Top module: `fa_tlb`

## Requirements
- R1: After reset, the block is in the following state:
  - `req_ready` is 1 and `resp_valid` is 0.
  - `fsr`, `far`, `tag_access` and `used_bits` are all zero.
  - Every entry is invalid.
- R2: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. Then `req_ready` is 0 during the next cycle, and `resp_valid` is 1 for exactly the cycle after that. After this, `req_ready` returns to 1.
- R3: An entry hits when all of these hold:
  - it is valid;
  - its global flag is set, or its context equals the lookup context;
  - its virtual page number equals the lookup page number in all unmasked bits.

  When no entry hits, `resp_kind` is MISS. The `resp_kind` encoding is 0 OK, 1 MISS, 2 FAULT, 3 PROT.
- R4: Size codes 0, 1, 2 and 3 select pages of 8 KiB, 64 KiB, 512 KiB and 4 MiB. For code s, the lowest 3*s bits of the page number are left out of the compare. On an OK response, those same low bits of `resp_ppn` come from the virtual address. The remaining bits come from the entry.
- R5: The lookup context is chosen as follows.
  - For data accesses, `req_ctx_sel` selects it: 0 is `primary_ctx`, 1 is `secondary_ctx`, 2 or 3 is nucleus (context 0).
  - For instruction fetches, `req_ctx_sel` is ignored. The context is `primary_ctx` when `trap_level_nz` is 0, and nucleus otherwise.
- R6: When several entries hit, the lowest-numbered one is used.
- R7: A hit faults under three conditions, each with its own status bit:
  - a user access to a privileged page sets bit 7;
  - a non-faulting load (`req_access`=2) to a side-effect page sets bit 8;
  - a load or store (`req_access` 0 or 1) to a no-fault-only page sets bit 9.

  Several of these bits may be set together. For a fetch (`req_access`=3), only the privilege check applies.
- R8: A store (`req_access`=1) that hits a non-writable page without an R7 fault reports PROT.
- R9: On FAULT or PROT, `fsr` is loaded with these fields:
  - bit 0 valid = 1;
  - bit 2 is set for a store;
  - bit 3 is set for a non-faulting load;
  - bit 4 is set when `cpu_priv` is 1;
  - bits 6:5 give the context type: 0 primary, 1 secondary, 2 nucleus;
  - bits 9:7 give the fault types from R7, which are all zero for PROT.
- R10: `fsr` bit 1 (overwrite) is set on a FAULT or PROT when `fsr` bit 0 was already 1. A `fsr_clear` pulse with no fault retiring in the same cycle zeroes `fsr`.
- R11: On FAULT or PROT, `far` takes the request address and `tag_access` takes {VA[63:13], lookup context}.
- R12: On MISS, `tag_access` takes {VA[63:13], lookup context}, while `fsr` and `far` keep their values.
- R13: On OK, `resp_perm` is set and the winning entry's bit in `used_bits` becomes 1. The `resp_perm` bits are bit 0 read, bit 1 write, bit 2 execute.
  - A data access gets read, plus write when the page is writable.
  - A fetch gets execute only.

  Writing an entry clears its used bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_va | input | 64 | Virtual address |
| req_access | input | 2 | 0 load, 1 store, 2 non-faulting load, 3 fetch |
| req_ctx_sel | input | 2 | Data context: 0 primary, 1 secondary, 2/3 nucleus |
| req_user | input | 1 | Access made in user mode |
| cpu_priv | input | 1 | Processor privileged state, recorded in status |
| trap_level_nz | input | 1 | Trap level is non-zero |
| primary_ctx | input | 13 | Primary context value |
| secondary_ctx | input | 13 | Secondary context value |
| resp_valid | output | 1 | Response present |
| resp_kind | output | 2 | 0 OK, 1 MISS, 2 FAULT, 3 PROT |
| resp_ppn | output | 28 | Physical page number (PA[40:13]) on OK |
| resp_perm | output | 3 | Granted permissions on OK: bit0 R, bit1 W, bit2 X |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_vpn | input | 51 | Entry virtual page number |
| wr_ctx | input | 13 | Entry context |
| wr_ppn | input | 28 | Entry physical page number |
| wr_valid | input | 1 | Entry valid flag |
| wr_global | input | 1 | Entry global flag |
| wr_priv | input | 1 | Entry privileged flag |
| wr_writable | input | 1 | Entry writable flag |
| wr_side_effect | input | 1 | Entry side-effect flag |
| wr_nfo | input | 1 | Entry no-fault-only flag |
| wr_size | input | 2 | Entry page-size code |
| fsr_clear | input | 1 | Clear the fault status word |
| fsr | output | 10 | Fault status word |
| far | output | 64 | Fault address |
| tag_access | output | 64 | Tag-access word |
| used_bits | output | 64 | Per-entry used flags |

## Verification
The hardest situation to create is two or more entries hitting at once. This needs duplicate pages that overlap through different page sizes, or a global entry that shadows a context-specific one. Tags that are merely random almost never collide. The stimulus therefore loads deliberate overlaps:
- a duplicated 8 KiB page in a low and a high slot;
- a 4 MiB page that covers a smaller page in a higher slot.

It then probes addresses inside the shared range. A second hard case is a mix of fault types in one response. It is reached by loading entries that carry several attributes at once, such as privileged plus no-fault-only, and issuing user accesses of each kind against them.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD   = 2'd0,
        ACC_STORE  = 2'd1,
        ACC_NFLOAD = 2'd2,
        ACC_FETCH  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RK_OK    = 2'd0,
        RK_MISS  = 2'd1,
        RK_FAULT = 2'd2,
        RK_PROT  = 2'd3
    } rkind_e;

    typedef enum logic [1:0] {
        CT_PRIMARY   = 2'd0,
        CT_SECONDARY = 2'd1,
        CT_NUCLEUS   = 2'd2
    } ctxty_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_MATCH = 2'd1,
        S_RESP  = 2'd2
    } tlb_state_e;

    typedef struct packed {
        logic       valid;
        logic       global;
        logic       priv;
        logic       writable;
        logic       side_eff;
        logic       nfo;
        logic [1:0] size;
    } tte_flags_t;

    localparam int FSR_W      = 10;
    localparam int FSR_VALID  = 0;
    localparam int FSR_OVWR   = 1;
    localparam int FSR_WRITE  = 2;
    localparam int FSR_NFL    = 3;
    localparam int FSR_PRIV   = 4;
    localparam int FSR_CT_LO  = 5;
    localparam int FSR_FT_PRV = 7;
    localparam int FSR_FT_SE  = 8;
    localparam int FSR_FT_NFO = 9;

    localparam int SIZE_STEP  = 3;

endpackage

// File: rtl/tlb_match_cell.sv
module tlb_match_cell
    import tlb_pkg::*;
#(
    parameter int VPN_W = 51,
    parameter int CTX_W = 13
) (
    input  logic [VPN_W-1:0] ent_vpn,
    input  logic [CTX_W-1:0] ent_ctx,
    input  tte_flags_t       ent_fl,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [CTX_W-1:0] lk_ctx,
    output logic             hit
);
    logic [VPN_W-1:0] keep_mask;
    logic             ctx_ok;
    logic             addr_ok;

    always_comb begin
        keep_mask = {VPN_W{1'b1}} << (SIZE_STEP * int'(ent_fl.size));
        ctx_ok    = ent_fl.global || (ent_ctx == lk_ctx);
        addr_ok   = (((ent_vpn ^ lk_vpn) & keep_mask) == '0);
        hit       = ent_fl.valid && ctx_ok && addr_ok;
    end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

    // R6: the chosen slot is one that actually matched
    always_comb begin
        if (any) begin
            p_grant_hits_r6: assert (vec[idx]);
        end
    end
endmodule

// File: rtl/tlb_access_check.sv
module tlb_access_check
    import tlb_pkg::*;
(
    input  tte_flags_t fl,
    input  acc_e       acc,
    input  logic       user,
    output logic       ft_priv,
    output logic       ft_se,
    output logic       ft_nfo,
    output logic       fault,
    output logic       prot
);
    always_comb begin
        ft_priv = user && fl.priv;
        ft_se   = 1'b0;
        ft_nfo  = 1'b0;
        unique case (acc)
            ACC_NFLOAD: ft_se  = fl.side_eff;
            ACC_LOAD,
            ACC_STORE:  ft_nfo = fl.nfo;
            ACC_FETCH:  ;
        endcase
        fault = ft_priv || ft_se || ft_nfo;
        prot  = !fault && (acc == ACC_STORE) && !fl.writable;
    end
endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES  = 64,
    parameter int VA_W     = 64,
    parameter int PA_W     = 41,
    parameter int CTX_W    = 13,
    parameter int PG_SHIFT = 13,
    localparam int VPN_W   = VA_W - PG_SHIFT,
    localparam int PPN_W   = PA_W - PG_SHIFT,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_va,
    input  logic [1:0]          req_access,
    input  logic [1:0]          req_ctx_sel,
    input  logic                req_user,
    input  logic                cpu_priv,
    input  logic                trap_level_nz,
    input  logic [CTX_W-1:0]    primary_ctx,
    input  logic [CTX_W-1:0]    secondary_ctx,
    output logic                resp_valid,
    output logic [1:0]          resp_kind,
    output logic [PPN_W-1:0]    resp_ppn,
    output logic [2:0]          resp_perm,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [VPN_W-1:0]    wr_vpn,
    input  logic [CTX_W-1:0]    wr_ctx,
    input  logic [PPN_W-1:0]    wr_ppn,
    input  logic                wr_valid,
    input  logic                wr_global,
    input  logic                wr_priv,
    input  logic                wr_writable,
    input  logic                wr_side_effect,
    input  logic                wr_nfo,
    input  logic [1:0]          wr_size,
    input  logic                fsr_clear,
    output logic [FSR_W-1:0]    fsr,
    output logic [VA_W-1:0]     far,
    output logic [VA_W-1:0]     tag_access,
    output logic [ENTRIES-1:0]  used_bits
);

    // ---------------- entry storage ----------------
    logic [VPN_W-1:0] ent_vpn [ENTRIES];
    logic [CTX_W-1:0] ent_ctx [ENTRIES];
    logic [PPN_W-1:0] ent_ppn [ENTRIES];
    tte_flags_t       ent_fl  [ENTRIES];
    logic [ENTRIES-1:0] used_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_vpn[wr_idx] <= wr_vpn;
            ent_ctx[wr_idx] <= wr_ctx;
            ent_ppn[wr_idx] <= wr_ppn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent_fl[i] <= '0;
        end else if (wr_en) begin
            ent_fl[wr_idx] <= '{valid: wr_valid, global: wr_global, priv: wr_priv,
                                writable: wr_writable, side_eff: wr_side_effect,
                                nfo: wr_nfo, size: wr_size};
        end
    end

    // ---------------- state machine ----------------
    tlb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = S_MATCH;   // accept
            S_MATCH: state_d = S_RESP;                   // resolve
            S_RESP:  state_d = S_IDLE;                   // retire
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- request capture ----------------
    logic [VA_W-1:0]  lk_va;
    acc_e             lk_acc;
    logic [CTX_W-1:0] lk_ctx;
    ctxty_e           lk_ctype;
    logic             lk_user;
    logic             lk_cpriv;
    logic [CTX_W-1:0] ctx_pick;
    ctxty_e           ctype_pick;

    always_comb begin
        if (acc_e'(req_access) == ACC_FETCH) begin
            if (trap_level_nz) begin
                ctx_pick   = '0;
                ctype_pick = CT_NUCLEUS;
            end else begin
                ctx_pick   = primary_ctx;
                ctype_pick = CT_PRIMARY;
            end
        end else begin
            unique case (req_ctx_sel)
                2'd0: begin ctx_pick = primary_ctx;   ctype_pick = CT_PRIMARY;   end
                2'd1: begin ctx_pick = secondary_ctx; ctype_pick = CT_SECONDARY; end
                default: begin ctx_pick = '0;         ctype_pick = CT_NUCLEUS;   end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_va    <= '0;
            lk_acc   <= ACC_LOAD;
            lk_ctx   <= '0;
            lk_ctype <= CT_PRIMARY;
            lk_user  <= 1'b0;
            lk_cpriv <= 1'b0;
        end else if (state_q == S_IDLE && req_valid) begin
            lk_va    <= req_va;
            lk_acc   <= acc_e'(req_access);
            lk_ctx   <= ctx_pick;
            lk_ctype <= ctype_pick;
            lk_user  <= req_user;
            lk_cpriv <= cpu_priv;
        end
    end

    // ---------------- parallel compare ----------------
    logic [ENTRIES-1:0] hit_vec;
    logic               any_hit;
    logic [IDX_W-1:0]   win_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
        tlb_match_cell #(.VPN_W(VPN_W), .CTX_W(CTX_W)) u_cell (
            .ent_vpn (ent_vpn[g]),
            .ent_ctx (ent_ctx[g]),
            .ent_fl  (ent_fl[g]),
            .lk_vpn  (lk_va[VA_W-1:PG_SHIFT]),
            .lk_ctx  (lk_ctx),
            .hit     (hit_vec[g])
        );
    end

    tlb_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
        .vec (hit_vec),
        .any (any_hit),
        .idx (win_idx)
    );

    logic             sel_hit;
    logic [IDX_W-1:0] sel_idx;
    tte_flags_t       sel_fl;
    logic [PPN_W-1:0] sel_ppn;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_hit <= 1'b0;
            sel_idx <= '0;
            sel_fl  <= '0;
            sel_ppn <= '0;
        end else if (state_q == S_MATCH) begin
            sel_hit <= any_hit;
            sel_idx <= win_idx;
            sel_fl  <= ent_fl[win_idx];
            sel_ppn <= ent_ppn[win_idx];
        end
    end

    // ---------------- classification ----------------
    logic ft_priv, ft_se, ft_nfo, is_fault, is_prot;

    tlb_access_check u_chk (
        .fl      (sel_fl),
        .acc     (lk_acc),
        .user    (lk_user),
        .ft_priv (ft_priv),
        .ft_se   (ft_se),
        .ft_nfo  (ft_nfo),
        .fault   (is_fault),
        .prot    (is_prot)
    );

    rkind_e           kind;
    logic [PPN_W-1:0] keep_ppn;

    always_comb begin
        if (!sel_hit)      kind = RK_MISS;
        else if (is_fault) kind = RK_FAULT;
        else if (is_prot)  kind = RK_PROT;
        else               kind = RK_OK;
        keep_ppn = {PPN_W{1'b1}} << (SIZE_STEP * int'(sel_fl.size));
    end

    // ---------------- output process ----------------
    always_comb begin
        req_ready  = (state_q == S_IDLE);
        resp_valid = (state_q == S_RESP);
        resp_kind  = resp_valid ? kind : RK_OK;
        resp_ppn   = '0;
        resp_perm  = '0;
        if (resp_valid && kind == RK_OK) begin
            resp_ppn = (sel_ppn & keep_ppn) | (lk_va[PA_W-1:PG_SHIFT] & ~keep_ppn);
            if (lk_acc == ACC_FETCH) resp_perm = 3'b100;
            else                     resp_perm = {1'b0, sel_fl.writable, 1'b1};
        end
    end

    // ---------------- fault registers ----------------
    logic             retire;
    logic [FSR_W-1:0] fsr_new;

    always_comb begin
        retire  = (state_q == S_RESP);
        fsr_new = '0;
        fsr_new[FSR_VALID]              = 1'b1;
        fsr_new[FSR_OVWR]               = fsr[FSR_VALID];
        fsr_new[FSR_WRITE]              = (lk_acc == ACC_STORE);
        fsr_new[FSR_NFL]                = (lk_acc == ACC_NFLOAD);
        fsr_new[FSR_PRIV]               = lk_cpriv;
        fsr_new[FSR_CT_LO+1:FSR_CT_LO]  = lk_ctype;
        fsr_new[FSR_FT_PRV]             = ft_priv;
        fsr_new[FSR_FT_SE]              = ft_se;
        fsr_new[FSR_FT_NFO]             = ft_nfo;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsr        <= '0;
            far        <= '0;
            tag_access <= '0;
        end else begin
            if (retire && (kind == RK_FAULT || kind == RK_PROT)) begin
                fsr        <= fsr_new;
                far        <= lk_va;
                tag_access <= {lk_va[VA_W-1:PG_SHIFT], lk_ctx};
            end else begin
                if (fsr_clear) fsr <= '0;
                if (retire && kind == RK_MISS)
                    tag_access <= {lk_va[VA_W-1:PG_SHIFT], lk_ctx};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
        end else begin
            if (retire && kind == RK_OK) used_q[sel_idx] <= 1'b1;
            if (wr_en)                   used_q[wr_idx]  <= 1'b0;
        end
    end

    assign used_bits = used_q;

    // ---------------- assertions ----------------
    p_accept_then_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !resp_valid) ##1 resp_valid);

    p_miss_keeps_fsr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == RK_MISS && !fsr_clear) |=> ($stable(fsr) && $stable(far)));

    p_fault_sets_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (resp_kind == RK_FAULT || resp_kind == RK_PROT))
        |=> (fsr[FSR_VALID] && far == $past(lk_va)));

    p_prot_only_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == RK_PROT) |-> (lk_acc == ACC_STORE));

    p_fetch_exec_only_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == RK_OK && lk_acc == ACC_FETCH) |-> (resp_perm == 3'b100));

endmodule

// File: tb/fa_tlb_tb.sv
`timescale 1ns/1ps
module fa_tlb_tb;
    localparam int N = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req_valid = 0, req_user = 0, cpu_priv = 0, trap_level_nz = 0;
    logic [63:0] req_va = '0;
    logic [1:0]  req_access = '0, req_ctx_sel = '0;
    logic [12:0] primary_ctx = 13'd7, secondary_ctx = 13'd21;
    logic        req_ready, resp_valid;
    logic [1:0]  resp_kind;
    logic [27:0] resp_ppn;
    logic [2:0]  resp_perm;
    logic        wr_en = 0, wr_valid = 0, wr_global = 0, wr_priv = 0, wr_writable = 0;
    logic        wr_side_effect = 0, wr_nfo = 0, fsr_clear = 0;
    logic [5:0]  wr_idx = '0;
    logic [50:0] wr_vpn = '0;
    logic [12:0] wr_ctx = '0;
    logic [27:0] wr_ppn = '0;
    logic [1:0]  wr_size = '0;
    logic [9:0]  fsr;
    logic [63:0] far, tag_access;
    logic [63:0] used_bits;

    fa_tlb u_dut (.*);

    // ---- reference state ----
    logic [50:0] m_vpn [N];
    logic [12:0] m_ctx [N];
    logic [27:0] m_ppn [N];
    bit          m_v[N], m_g[N], m_p[N], m_w[N], m_e[N], m_n[N];
    int          m_sz[N];
    logic [63:0] m_used = '0;
    logic [9:0]  m_fsr = '0;
    logic [63:0] m_far = '0, m_tag = '0;

    int n_chk = 0, n_fail = 0;
    bit mon_en = 0;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compare architectural registers every cycle
    always @(negedge clk) begin
        if (mon_en) begin
            chk(fsr == m_fsr, "R9/R10 fsr", 64'(fsr), 64'(m_fsr));
            chk(far == m_far, "R11 far", far, m_far);
            chk(tag_access == m_tag, "R11/R12 tag_access", tag_access, m_tag);
            chk(used_bits == m_used, "R13 used_bits", used_bits, m_used);
        end
    end

    task automatic load(int idx, logic [50:0] vpn, logic [12:0] ctx, logic [27:0] ppn,
                        bit v, bit g, bit p, bit w, bit e, bit n, int sz);
        @(negedge clk);
        wr_en = 1; wr_idx = 6'(idx); wr_vpn = vpn; wr_ctx = ctx; wr_ppn = ppn;
        wr_valid = v; wr_global = g; wr_priv = p; wr_writable = w;
        wr_side_effect = e; wr_nfo = n; wr_size = 2'(sz);
        @(posedge clk); #1;
        m_vpn[idx] = vpn; m_ctx[idx] = ctx; m_ppn[idx] = ppn;
        m_v[idx] = v; m_g[idx] = g; m_p[idx] = p; m_w[idx] = w;
        m_e[idx] = e; m_n[idx] = n; m_sz[idx] = sz;
        m_used[idx] = 1'b0;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic clear_fsr();
        @(negedge clk);
        fsr_clear = 1;
        @(posedge clk); #1;
        m_fsr = '0;
        @(negedge clk);
        fsr_clear = 0;
    endtask

    // behavioural lookup; returns kind 0 OK 1 MISS 2 FAULT 3 PROT
    task automatic lookup(string tag, logic [63:0] va, int acc, int csel,
                          bit user, bit cp, bit tl);
        logic [12:0] ectx;
        int ctype, win, kind, sh;
        logic [27:0] eppn;
        logic [2:0]  eperm;
        bit fp, fse, fnfo;
        if (acc == 3) begin
            ectx = tl ? 13'd0 : primary_ctx; ctype = tl ? 2 : 0;
        end else if (csel == 0) begin
            ectx = primary_ctx; ctype = 0;
        end else if (csel == 1) begin
            ectx = secondary_ctx; ctype = 1;
        end else begin
            ectx = 13'd0; ctype = 2;
        end
        win = -1;
        for (int i = 0; i < N; i++) begin
            if (win < 0 && m_v[i] && (m_g[i] || m_ctx[i] == ectx) &&
                ((va[63:13] >> (3 * m_sz[i])) == (m_vpn[i] >> (3 * m_sz[i]))))
                win = i;
        end
        fp = 0; fse = 0; fnfo = 0; eppn = '0; eperm = '0;
        if (win < 0) kind = 1;
        else begin
            fp   = user && m_p[win];
            fse  = (acc == 2) && m_e[win];
            fnfo = (acc < 2) && m_n[win];
            if (fp || fse || fnfo) kind = 2;
            else if (acc == 1 && !m_w[win]) kind = 3;
            else begin
                kind = 0;
                sh = 3 * m_sz[win];
                eppn = ((m_ppn[win] >> sh) << sh) | (va[40:13] % (28'd1 << sh));
                eperm = (acc == 3) ? 3'b100 : {1'b0, m_w[win], 1'b1};
            end
        end
        @(negedge clk);
        req_valid = 1; req_va = va; req_access = 2'(acc); req_ctx_sel = 2'(csel);
        req_user = user; cpu_priv = cp; trap_level_nz = tl;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready && !resp_valid, {"R2 busy ", tag}, {62'd0, req_ready, resp_valid}, 64'd0);
        @(negedge clk);
        chk(resp_valid && resp_kind == 2'(kind), {"R3/R7/R8 kind ", tag},
            64'(resp_kind), 64'(kind));
        chk(resp_ppn == eppn, {"R4 ppn ", tag}, 64'(resp_ppn), 64'(eppn));
        chk(resp_perm == eperm, {"R13 perm ", tag}, 64'(resp_perm), 64'(eperm));
        @(posedge clk); #1;
        if (kind != 0) m_tag = {va[63:13], ectx};
        if (kind >= 2) begin
            m_fsr = {fnfo, fse, fp, 2'(ctype), cp, (acc == 2), (acc == 1), m_fsr[0], 1'b1};
            m_far = va;
        end
        if (kind == 0) m_used[win] = 1'b1;
        @(negedge clk);
        chk(req_ready && !resp_valid, {"R2 idle ", tag}, {62'd0, req_ready, resp_valid}, 64'h2);
    endtask

    localparam logic [50:0] V5   = 51'h1_2345_6789_0AB0;
    localparam logic [50:0] VDUP = 51'h0_0BAD_0000_1000;
    localparam logic [50:0] VGL  = 51'h0_0000_0000_4000;
    localparam logic [50:0] VS1  = 51'h0_0000_0010_0000;
    localparam logic [50:0] VS2  = 51'h0_0000_0020_0000;
    localparam logic [50:0] VS3  = 51'h0_0000_0040_0000;
    localparam logic [50:0] VF   = 51'h0_0000_0080_0000;

    bit done = 0;

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_g[i] = 0; m_p[i] = 0; m_w[i] = 0; m_e[i] = 0; m_n[i] = 0;
            m_sz[i] = 0; m_vpn[i] = '0; m_ctx[i] = '0; m_ppn[i] = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !resp_valid, "R1 handshake", {62'd0, req_ready, resp_valid}, 64'h2);
        chk(fsr == 0 && far == 0 && tag_access == 0 && used_bits == 0, "R1 registers",
            64'(fsr) | far | tag_access | used_bits, 64'd0);
        mon_en = 1;
        lookup("R1 empty miss", {V5, 13'h0}, 0, 0, 0, 0, 0);

        load(5,  V5,   13'd7,  28'h1234560, 1, 0, 0, 1, 0, 0, 0);
        load(6,  VGL,  13'd99, 28'h0777000, 1, 1, 0, 0, 0, 0, 0);
        load(3,  VDUP, 13'd7,  28'h0AAAAAA, 1, 0, 0, 1, 0, 0, 0);
        load(20, VDUP, 13'd7,  28'h0BBBBBB, 1, 0, 0, 1, 0, 0, 0);
        load(10, VS1,  13'd7,  28'h0100005, 1, 0, 0, 1, 0, 0, 1);
        load(11, VS2,  13'd7,  28'h020003F, 1, 0, 0, 1, 0, 0, 2);
        load(12, VS3,  13'd21, 28'h04001FF, 1, 0, 0, 1, 0, 0, 3);
        load(13, VF,         13'd7, 28'h0000013, 1, 0, 1, 1, 0, 0, 0);
        load(14, VF + 51'd1, 13'd7, 28'h0000014, 1, 0, 0, 1, 1, 0, 0);
        load(15, VF + 51'd2, 13'd7, 28'h0000015, 1, 0, 0, 1, 0, 1, 0);
        load(16, VF + 51'd3, 13'd7, 28'h0000016, 1, 0, 1, 0, 0, 1, 0);
        load(17, VF + 51'd4, 13'd7, 28'h0000017, 1, 0, 0, 0, 0, 0, 0);
        load(18, VF + 51'd5, 13'd0, 28'h0000018, 1, 0, 0, 1, 0, 0, 0);
        load(40, VS3 + 51'h40, 13'd21, 28'h0999999, 1, 0, 0, 1, 0, 0, 0);
        load(41, VS1 + 51'h200, 13'd7, 28'h0555555, 0, 0, 0, 1, 0, 0, 0);

        // R3 hit / context mismatch / global / invalid entry
        lookup("R3 hit", {V5, 13'h123}, 0, 0, 0, 0, 0);
        lookup("R3 ctx mismatch", {V5, 13'h0}, 0, 1, 0, 0, 0);
        lookup("R3 global", {VGL, 13'h4}, 0, 1, 0, 0, 0);
        lookup("R3 invalid entry", {VS1 + 51'h200, 13'h0}, 0, 0, 0, 0, 0);
        // R4 page sizes
        lookup("R4 64K inside", {VS1 + 51'h5, 13'h1}, 0, 0, 0, 0, 0);
        lookup("R4 64K outside", {VS1 + 51'h8, 13'h1}, 0, 0, 0, 0, 0);
        lookup("R4 512K inside", {VS2 + 51'h2A, 13'h0}, 1, 0, 0, 0, 0);
        lookup("R4 512K outside", {VS2 + 51'h40, 13'h0}, 0, 0, 0, 0, 0);
        lookup("R4 4M inside", {VS3 + 51'h1A5, 13'h0}, 0, 1, 0, 0, 0);
        // R6 overlap: 4M slot 12 covers slot 40; duplicate pages slots 3 and 20
        lookup("R6 size overlap", {VS3 + 51'h40, 13'h0}, 0, 1, 0, 0, 0);
        lookup("R6 duplicate", {VDUP, 13'h0}, 0, 0, 0, 0, 0);
        // R5 context selection
        lookup("R5 secondary", {VS3, 13'h0}, 2, 1, 0, 0, 0);
        lookup("R5 nucleus data", {VF + 51'd5, 13'h0}, 0, 2, 0, 0, 0);
        lookup("R5 nucleus sel3", {VF + 51'd5, 13'h0}, 0, 3, 0, 0, 0);
        lookup("R5 fetch tl0", {V5, 13'h0}, 3, 2, 0, 0, 0);
        lookup("R5 fetch tl1", {VF + 51'd5, 13'h0}, 3, 1, 0, 0, 1);
        lookup("R5 fetch tl1 miss", {V5, 13'h0}, 3, 0, 0, 0, 1);
        // R7 faults
        lookup("R7 user priv", {VF, 13'h0}, 0, 0, 1, 0, 0);
        lookup("R10 overwrite", {VF + 51'd1, 13'h0}, 2, 0, 0, 1, 0);
        clear_fsr();
        lookup("R7 nfo load", {VF + 51'd2, 13'h0}, 0, 0, 0, 1, 0);
        clear_fsr();
        lookup("R7 combined", {VF + 51'd3, 13'h0}, 1, 0, 1, 0, 0);
        lookup("R7 fetch nfo ok", {VF + 51'd2, 13'h0}, 3, 0, 0, 0, 0);
        lookup("R7 fetch priv", {VF, 13'h0}, 3, 0, 1, 0, 1);
        lookup("R7 kernel priv ok", {VF, 13'h0}, 0, 0, 0, 1, 0);
        // R12 miss after fault keeps fsr/far
        lookup("R12 miss", {51'h7_7777_0000_0000, 13'h0}, 1, 0, 0, 0, 0);
        clear_fsr();
        // R8 protection
        lookup("R8 store ro", {VF + 51'd4, 13'h0}, 1, 0, 0, 1, 0);
        lookup("R8 load ro", {VF + 51'd4, 13'h0}, 0, 0, 0, 0, 0);
        lookup("R8 global ro store", {VGL, 13'h0}, 1, 0, 0, 0, 0);
        chk(fsr[1] == 1'b1, "R10 overwrite bit", 64'(fsr[1]), 64'd1);
        // R13 rewrite clears used
        load(5, V5, 13'd7, 28'h1234560, 1, 0, 0, 0, 0, 0, 0);
        chk(used_bits[5] == 1'b0, "R13 used cleared by write", 64'(used_bits[5]), 64'd0);

        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            int pick, acc, off;
            logic [50:0] vpn;
            pick = $urandom_range(0, 7);
            case (pick)
                0: vpn = V5;   1: vpn = VGL;  2: vpn = VDUP; 3: vpn = VS1;
                4: vpn = VS2;  5: vpn = VS3;  6: vpn = VF;   default: vpn = 51'h3_0000_0000_0000;
            endcase
            off = $urandom_range(0, 511);
            if ($urandom_range(0, 1) == 1) vpn = vpn + 51'(off % 8);
            else vpn = vpn ^ 51'(off);
            acc = $urandom_range(0, 3);
            lookup("R3 mixed", {vpn, 13'(off)}, acc, $urandom_range(0, 3),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)));
            if ($urandom_range(0, 5) == 0) clear_fsr();
        end

        done = 1;
        mon_en = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule